// File: doc/BRIEF.md
# Sync-Edge Clock Source Selector

This block decides, cycle by cycle on a fast system clock, where the start of each switching period comes from. An active-low synchronization input (already digital) is passed through a two-flop synchronizer, its falling edges are detected, and the number of system cycles between consecutive falling edges is measured. While that input is idle or too slow, a free-running internal divider marks a new period every `INT_PERIOD` cycles. Once the input proves fast enough, each of its falling edges starts a period directly, so the converter's phase follows the external clock.

Source choice is made by a three-state machine. `SRC_INT` is internal operation. It moves to `SRC_ARM` ("qualify") on a falling edge whose interval is at or below the threshold. From `SRC_ARM` a second qualifying edge moves to `SRC_EXT`, and staleness (no edge for more than the threshold) returns to `SRC_INT`. `SRC_EXT` stays put while edges keep arriving, and falls back to `SRC_INT` ("timeout") once the interval counter passes the threshold with no edge. That fallback emits a strobe at once and restarts the internal divider. A spacing guard drops any strobe that would land closer than `MIN_GAP` cycles to the previous one.

With the defaults (100 MHz system clock) the threshold is 333 cycles, which is about 300 kHz. The internal period is 100 cycles (1 MHz), and the spacing guard is 6 cycles (60 ns).

Top module: `sync_clk_sel`

## Requirements
- R1: While `rst_n` is low, `strobe_o`, `ext_sel_o` and `period_o` are all 0.
- R2: With `sync_n` held high, `strobe_o` pulses every `INT_PERIOD` (100) cycles with `ext_sel_o` = 0. The first pulse comes 100 cycles after reset release.
- R3: At each falling edge of `sync_n`, `period_o` takes the number of cycles since the previous falling edge, saturated at `THRESH_CYC`+1 (334). That value also applies when no earlier edge exists.
- R4: `ext_sel_o` (1 = external) rises only after two consecutive falling-edge intervals of at most `THRESH_CYC`. One qualifying interval alone leaves `ext_sel_o` at 0.
- R5: In external mode, `strobe_o` pulses exactly 3 cycles after `sync_n` is driven low: two synchronizer stages plus the output register.
- R6: An interval of exactly `THRESH_CYC` (333) qualifies. An interval of `THRESH_CYC`+1 (334) does not.
- R7: In external mode, if `THRESH_CYC`+1 cycles pass with no falling edge, `ext_sel_o` drops and `strobe_o` pulses in that same cycle. Internal pulses then follow every `INT_PERIOD` cycles from that pulse.
- R8: Two `strobe_o` pulses are never fewer than `MIN_GAP` (6) cycles apart. A period start that would violate this is dropped, not delayed.
- R9: A timeout while qualifying returns to internal mode with no extra pulse, and the internal phase continues unchanged.
- R10: `strobe_o` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_n | input | 1 | External synchronization input, falling edge active |
| strobe_o | output | 1 | One-cycle switching-period start |
| ext_sel_o | output | 1 | 1 when periods follow `sync_n`, 0 when internal |
| period_o | output | CNT_W | Last measured falling-edge interval in cycles, saturated |

## Verification
A wrong state in the selector shows up on `strobe_o` within one period. A stuck `SRC_ARM` keeps internal pulses where external ones are due, and a premature `SRC_EXT` drops the internal pulse train. A bad interval counter shifts the fallback pulse away from exactly 334 cycles after the last edge, or reports the wrong `period_o` on the very next edge. Every pulse is therefore checked against its predicted cycle and source flag, so a misplaced, missing or extra strobe is caught at the pulse where it occurs.

// File: rtl/sync_sel_pkg.sv
package sync_sel_pkg;
    typedef enum logic [1:0] {
        SRC_INT = 2'd0,
        SRC_ARM = 2'd1,
        SRC_EXT = 2'd2
    } src_state_e;
endpackage

// File: rtl/sync_fall_det.sv
module sync_fall_det #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_n,
    output logic fall
);
    logic [STAGES-1:0] chain_q;
    logic              last_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '1;
            last_q  <= 1'b1;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], sig_n};
            last_q  <= chain_q[STAGES-1];
        end
    end

    assign fall = last_q & ~chain_q[STAGES-1];
endmodule

// File: rtl/edge_interval_meter.sv
module edge_interval_meter #(
    parameter int THRESH_CYC = 333,
    parameter int CNT_W      = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fall,
    output logic [CNT_W-1:0] cur_cnt,
    output logic             short_ok,
    output logic             stale
);
    localparam logic [CNT_W-1:0] SAT = CNT_W'(THRESH_CYC + 1);
    localparam logic [CNT_W-1:0] LIM = CNT_W'(THRESH_CYC);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= SAT;
        else if (fall)
            cnt_q <= CNT_W'(1);
        else if (cnt_q != SAT)
            cnt_q <= cnt_q + 1'b1;
    end

    assign cur_cnt  = cnt_q;
    assign short_ok = fall && (cnt_q <= LIM);
    assign stale    = (cnt_q == SAT);
endmodule

// File: rtl/period_gen.sv
module period_gen #(
    parameter int INT_PERIOD = 100,
    parameter int W          = $clog2(INT_PERIOD)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic tick
);
    localparam logic [W-1:0] LAST = W'(INT_PERIOD - 1);

    logic [W-1:0] div_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            div_q <= '0;
        else if (restart || div_q == LAST)
            div_q <= '0;
        else
            div_q <= div_q + 1'b1;
    end

    assign tick = (div_q == LAST);
endmodule

// File: rtl/sync_clk_sel.sv
module sync_clk_sel
    import sync_sel_pkg::*;
#(
    parameter int  THRESH_CYC  = 333,
    parameter int  INT_PERIOD  = 100,
    parameter int  MIN_GAP     = 6,
    parameter int  SYNC_STAGES = 2,
    localparam int CNT_W       = $clog2(THRESH_CYC + 2)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sync_n,
    output logic             strobe_o,
    output logic             ext_sel_o,
    output logic [CNT_W-1:0] period_o
);
    localparam int             GAP_W   = $clog2(MIN_GAP + 1);
    localparam logic [GAP_W-1:0] GAP_MAX = GAP_W'(MIN_GAP);

    logic             fall, short_ok, stale, tick, restart;
    logic [CNT_W-1:0] cur_cnt;
    src_state_e       st_q, st_nxt;
    logic             req, strobe_d;
    logic [GAP_W-1:0] gap_q;

    sync_fall_det #(.STAGES(SYNC_STAGES)) u_fall (
        .clk(clk), .rst_n(rst_n), .sig_n(sync_n), .fall(fall)
    );

    edge_interval_meter #(.THRESH_CYC(THRESH_CYC), .CNT_W(CNT_W)) u_meter (
        .clk(clk), .rst_n(rst_n), .fall(fall),
        .cur_cnt(cur_cnt), .short_ok(short_ok), .stale(stale)
    );

    period_gen #(.INT_PERIOD(INT_PERIOD)) u_int (
        .clk(clk), .rst_n(rst_n), .restart(restart), .tick(tick)
    );

    // next state and period-start request
    always_comb begin
        st_nxt  = st_q;
        req     = 1'b0;
        restart = 1'b0;
        unique case (st_q)
            SRC_INT: begin
                req = tick;
                if (short_ok)
                    st_nxt = SRC_ARM;
            end
            SRC_ARM: begin
                req = tick;
                if (stale) begin
                    st_nxt = SRC_INT;
                end else if (fall) begin
                    st_nxt = SRC_EXT;
                    req    = 1'b1;
                end
            end
            SRC_EXT: begin
                if (stale) begin
                    st_nxt  = SRC_INT;
                    req     = 1'b1;
                    restart = 1'b1;
                end else begin
                    req = fall;
                end
            end
            default: st_nxt = SRC_INT;
        endcase
    end

    assign strobe_d = req && (gap_q >= GAP_MAX);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= SRC_INT;
        else
            st_q <= st_nxt;
    end

    // registered outputs and spacing guard
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            strobe_o  <= 1'b0;
            ext_sel_o <= 1'b0;
            period_o  <= '0;
            gap_q     <= GAP_MAX;
        end else begin
            strobe_o  <= strobe_d;
            ext_sel_o <= (st_nxt == SRC_EXT);
            if (fall)
                period_o <= cur_cnt;
            if (strobe_d)
                gap_q <= GAP_W'(1);
            else if (gap_q != GAP_MAX)
                gap_q <= gap_q + 1'b1;
        end
    end
endmodule

// File: rtl/sync_clk_sel_chk.sv
module sync_clk_sel_chk #(
    parameter int  THRESH_CYC = 333,
    parameter int  MIN_GAP    = 6,
    localparam int CNT_W      = $clog2(THRESH_CYC + 2)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             strobe_o,
    input logic             ext_sel_o,
    input logic [CNT_W-1:0] period_o
);
    localparam int               GW   = $clog2(MIN_GAP + 1) + 1;
    localparam logic [GW-1:0]    GMAX = GW'(MIN_GAP);
    localparam logic [CNT_W-1:0] LIM  = CNT_W'(THRESH_CYC);
    localparam logic [CNT_W-1:0] SAT  = CNT_W'(THRESH_CYC + 1);

    logic [GW-1:0] since_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            since_q <= GMAX;
        else if (strobe_o)
            since_q <= GW'(1);
        else if (since_q != GMAX)
            since_q <= since_q + 1'b1;
    end

    // R10
    strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_o |=> !strobe_o);

    // R8
    strobe_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_o |-> since_q >= GMAX);

    // R7
    fallback_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ext_sel_o) |-> strobe_o);

    // R4
    ext_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ext_sel_o) |-> period_o <= LIM);

    // R3
    period_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        period_o <= SAT);

    // R6
    ext_strobe_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_o && ext_sel_o) |-> period_o <= LIM);
endmodule

bind sync_clk_sel sync_clk_sel_chk #(.THRESH_CYC(THRESH_CYC), .MIN_GAP(MIN_GAP)) u_chk (
    .clk(clk), .rst_n(rst_n), .strobe_o(strobe_o),
    .ext_sel_o(ext_sel_o), .period_o(period_o)
);

// File: tb/sync_clk_sel_tb.sv
module sync_clk_sel_tb;
    localparam int CW = $clog2(333 + 2);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sync_n = 1'b1;
    logic          strobe_o, ext_sel_o;
    logic [CW-1:0] period_o;

    int cyc = 0;
    int checks = 0;
    int errors = 0;
    int base = 0;
    bit done = 1'b0;

    typedef struct {
        int    t;
        bit    ext;
        string tag;
    } exp_t;

    exp_t exp_q[$];

    sync_clk_sel u_dut (
        .clk(clk), .rst_n(rst_n), .sync_n(sync_n),
        .strobe_o(strobe_o), .ext_sel_o(ext_sel_o), .period_o(period_o)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic push(input int t, input bit ext, input string tag);
        exp_t e;
        e.t = base + t; e.ext = ext; e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic push_run(input int first, input int last, input string tag);
        for (int t = first; t <= last; t += 100) push(t, 1'b0, tag);
    endtask

    task automatic wait_to(input int t);
        while (cyc < base + t) @(negedge clk);
    endtask

    task automatic drive_fall(input int t);
        wait_to(t);
        sync_n = 1'b0;
        repeat (10) @(negedge clk);
        sync_n = 1'b1;
    endtask

    // monitor: every strobe must match the next expected item
    always @(negedge clk) begin
        if (rst_n && strobe_o && !done) begin
            if (exp_q.size() == 0) begin
                chk("R10", "unexpected strobe at cycle", cyc, -1);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk(e.tag, "strobe cycle", cyc, e.t);
                chk(e.tag, "ext_sel at strobe", int'(ext_sel_o), int'(e.ext));
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", "strobe in reset", int'(strobe_o), 0);
        chk("R1", "ext_sel in reset", int'(ext_sel_o), 0);
        chk("R1", "period in reset", int'(period_o), 0);
        while (cyc < 5) @(negedge clk);
        base = cyc;
        rst_n = 1'b1;

        // expected strobe schedule (cycles after reset release)
        push_run(100, 600, "R2");           // internal; the 602 entry strobe is a runt
        push(682, 1'b1, "R8");              // first external start after dropped runt
        push(762, 1'b1, "R5");
        push(842, 1'b1, "R5");
        push(1176, 1'b0, "R7");             // timeout: immediate strobe
        push_run(1276, 2876, "R7");         // restarted internal phase
        push(2969, 1'b1, "R6");             // 333-cycle intervals accepted
        push(3303, 1'b0, "R7");
        push_run(3403, 4903, "R6");         // 334-cycle intervals rejected
        push_run(5003, 5303, "R9");         // qualify timeout keeps phase

        drive_fall(439);
        drive_fall(519);
        wait_to(530);
        chk("R4", "ext_sel after one good interval", int'(ext_sel_o), 0);
        drive_fall(599);
        wait_to(603);
        chk("R4", "ext_sel after two good intervals", int'(ext_sel_o), 1);
        drive_fall(679);
        wait_to(690);
        chk("R3", "period at 80-cycle spacing", int'(period_o), 80);
        drive_fall(759);
        drive_fall(839);
        wait_to(1180);
        chk("R7", "ext_sel after timeout", int'(ext_sel_o), 0);

        drive_fall(1400);
        drive_fall(1800);
        wait_to(1810);
        chk("R3", "saturated period", int'(period_o), 334);
        chk("R4", "ext_sel with slow edges", int'(ext_sel_o), 0);

        drive_fall(2300);
        drive_fall(2633);
        wait_to(2640);
        chk("R6", "period at threshold", int'(period_o), 333);
        drive_fall(2966);
        wait_to(2975);
        chk("R6", "ext_sel at threshold spacing", int'(ext_sel_o), 1);

        drive_fall(3600);
        drive_fall(3934);
        wait_to(3940);
        chk("R6", "period one past threshold", int'(period_o), 334);
        drive_fall(4268);
        wait_to(4280);
        chk("R6", "ext_sel at 334 spacing", int'(ext_sel_o), 0);

        drive_fall(4668);
        drive_fall(4748);
        wait_to(4760);
        chk("R9", "ext_sel while qualifying", int'(ext_sel_o), 0);
        wait_to(5090);
        chk("R9", "ext_sel after qualify timeout", int'(ext_sel_o), 0);
        wait_to(5320);

        chk("R2", "missing expected strobes", exp_q.size(), 0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual cycle %0d expected end before 20000", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule